// File: doc/BRIEF.md
# Byte-Wide Table Access Unit

This unit gives a processor core byte-granular access to constant data held in a program memory that is organised in 16-bit words. Every word therefore holds two data bytes. A 21-bit pointer register holds a byte address. Bit 0 of that address picks the byte lane, and the bits above it pick the word. A one-byte latch register holds the byte last fetched from memory, or the byte waiting to be stored. Each transfer moves exactly one byte.

The host loads the pointer and the latch directly and can read both back at any time. It issues read or write commands, and each command carries a pointer-update mode. The memory is a synchronous RAM inside the unit. It has a 16-bit word port with one write enable per byte lane, so a write changes only the addressed byte. A single-cycle done pulse marks the end of every command.

Top module: `tbl_access`

## Requirements
- R1: After a synchronous active-low reset, the pointer reads 0, the latch reads 0 and done is low.
- R2: A pointer load at a clock edge places the supplied 21-bit value on the pointer output after that edge.
- R3: A latch load at a clock edge places the supplied byte on the latch output after that edge. The latch keeps its value whenever it is neither loaded nor filled by a read.
- R4: A read command sampled at edge N fetches the byte at the effective address. Word address = address bits [MEM_AW:1]. Lane bit 0 selects the low byte [7:0] when 0 and the high byte [15:8] when 1. The byte appears in the latch after edge N+1, and done is high for exactly the cycle after edge N+1.
- R5: A write command stores the latch value present at the command edge into the lane chosen by address bit 0 only. The other byte of the word keeps its content. Done pulses with the same timing as for a read.
- R6: Mode encoding: 00 uses the pointer and leaves it unchanged. 01 uses the pointer and then adds 1. 10 uses the pointer and then subtracts 1. 11 adds 1 first and uses the incremented value, which the pointer keeps.
- R7: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF plus 1 gives 0, and 0 minus 1 gives 0x1FFFFF.
- R8: When read and write commands arrive in the same cycle, only the read is carried out. Memory is left unwritten, and the pointer moves once.
- R9: When a pointer load coincides with a command, the access uses the old pointer and the loaded value replaces any mode update.
- R10: When a latch load coincides with the completion edge of a read, the fetched byte wins.
- R11: Without a command or a load, the pointer holds its value and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_ld_i | input | 1 | Load pointer from ptr_din_i |
| ptr_din_i | input | 21 | Pointer load value |
| lat_ld_i | input | 1 | Load latch from lat_din_i |
| lat_din_i | input | 8 | Latch load value |
| rd_req_i | input | 1 | Read command |
| wr_req_i | input | 1 | Write command |
| mode_i | input | 2 | Pointer update mode for the command |
| ptr_o | output | 21 | Current pointer |
| lat_o | output | 8 | Current latch |
| done_o | output | 1 | Command completion pulse |

## Verification
The bench drives colliding host actions in one cycle. A pointer load is issued in the same cycle as a post-increment read. A latch load is issued in the exact cycle in which a read completes. A read command is raised together with a write command. Each collision is judged at the ports. The bench compares the final pointer, the latch contents and follow-up reads of the touched bytes against a byte-addressed reference model kept in the bench. This shows which side won and that the losing action left no trace in memory.

// File: rtl/tbl_pkg.sv
// Package: shared types of the table access unit.
// Assumes: the mode encoding is fixed by the host interface.
package tbl_pkg;
    typedef enum logic [1:0] {
        MODE_KEEP     = 2'b00,
        MODE_POST_INC = 2'b01,
        MODE_POST_DEC = 2'b10,
        MODE_PRE_INC  = 2'b11
    } tbl_mode_e;
endpackage

// File: rtl/tbl_ptr_unit.sv
// Module: byte-address pointer register with command-driven update.
// Computes the effective access address for the current command and the
//   next pointer value. A direct load overrides any mode update.
// Assumes: step is high only in a cycle in which a command is accepted.
module tbl_ptr_unit
    import tbl_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    input  logic             step,
    input  tbl_mode_e        mode,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] acc_addr
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_nxt;

    // Purpose: neighbour values, wrapping modulo 2^PTR_W.
    always_comb begin
        ptr_inc = ptr_q + ONE;
        ptr_dec = ptr_q - ONE;
    end

    // Purpose: the address used by the access (pre-increment uses ptr+1).
    always_comb begin
        acc_addr = (mode == MODE_PRE_INC) ? ptr_inc : ptr_q;
    end

    // Purpose: select the next pointer value.
    always_comb begin
        ptr_nxt = ptr_q;
        if (ld) begin
            ptr_nxt = ld_val;
        end else if (step) begin
            unique case (mode)
                MODE_KEEP:     ptr_nxt = ptr_q;
                MODE_POST_INC: ptr_nxt = ptr_inc;
                MODE_POST_DEC: ptr_nxt = ptr_dec;
                MODE_PRE_INC:  ptr_nxt = ptr_inc;
                default:       ptr_nxt = ptr_q;
            endcase
        end
    end

    // Purpose: the pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_nxt;
    end

    AST_PTR_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && mode == MODE_POST_INC) |=> ptr_q == $past(ptr_q) + ONE); // R6
    AST_PTR_POST_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && mode == MODE_POST_DEC) |=> ptr_q == $past(ptr_q) - ONE); // R7
    AST_PTR_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ptr_q == $past(ld_val)); // R9
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !step) |=> $stable(ptr_q)); // R11
endmodule

// File: rtl/tbl_prog_mem.sv
// Module: synchronous word-organised program memory with byte-lane writes.
// Read data is registered, and the read returns the old content
//   (read-before-write).
// Assumes: contents are not reset; the host writes a location before
//   reading it.
module tbl_prog_mem #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [DW/8-1:0] be,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int NB    = DW / 8;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: one write port per byte lane.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && be[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    // Purpose: registered word read.
    always_ff @(posedge clk) begin
        rdata <= mem[addr];
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $countones(be) == 1); // R5
endmodule

// File: rtl/tbl_access.sv
// Module: byte-wide table access unit (top).
// Provides a byte pointer and a one-byte latch onto a 16-bit word memory.
// A read completes one clock after its command and fills the latch.
// A write stores the latch into one byte lane at the command edge.
// Assumes: when read and write are requested together, the read wins.
module tbl_access
    import tbl_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int MEM_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_ld_i,
    input  logic [PTR_W-1:0] ptr_din_i,
    input  logic             lat_ld_i,
    input  logic [7:0]       lat_din_i,
    input  logic             rd_req_i,
    input  logic             wr_req_i,
    input  logic [1:0]       mode_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [7:0]       lat_o,
    output logic             done_o
);
    localparam int WORD_W = 16;
    localparam int LANES  = WORD_W / 8;

    tbl_mode_e          mode;
    logic               go;
    logic               wr_go;
    logic [PTR_W-1:0]   acc_addr;
    logic [MEM_AW-1:0]  word_addr;
    logic               lane;
    logic [LANES-1:0]   be;
    logic [WORD_W-1:0]  rdata;
    logic               rd_pend_q;
    logic               any_pend_q;
    logic               lane_q;
    logic [7:0]         lat_q;
    logic               done_q;
    logic               unused_hi;

    // Purpose: decode the command and split the effective address.
    always_comb begin
        mode      = tbl_mode_e'(mode_i);
        go        = rd_req_i | wr_req_i;
        wr_go     = wr_req_i & ~rd_req_i;
        word_addr = acc_addr[MEM_AW:1];
        lane      = acc_addr[0];
        be        = lane ? 2'b10 : 2'b01;
        unused_hi = ^acc_addr[PTR_W-1:MEM_AW+1];
    end

    tbl_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ptr_ld_i),
        .ld_val   (ptr_din_i),
        .step     (go),
        .mode     (mode),
        .ptr_q    (ptr_o),
        .acc_addr (acc_addr)
    );

    tbl_prog_mem #(.AW(MEM_AW), .DW(WORD_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_go),
        .be    (be),
        .addr  (word_addr),
        .wdata ({lat_q, lat_q}),
        .rdata (rdata)
    );

    // Purpose: track commands in flight for the one-clock completion stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q  <= 1'b0;
            any_pend_q <= 1'b0;
            lane_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            rd_pend_q  <= rd_req_i;
            any_pend_q <= go;
            lane_q     <= lane;
            done_q     <= any_pend_q;
        end
    end

    // Purpose: the latch; a read completion has priority over a host load.
    always_ff @(posedge clk) begin
        if (!rst_n)         lat_q <= 8'h00;
        else if (rd_pend_q) lat_q <= lane_q ? rdata[15:8] : rdata[7:0];
        else if (lat_ld_i)  lat_q <= lat_din_i;
    end

    assign lat_o  = lat_q;
    assign done_o = done_q;

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i || wr_req_i) |=> ##1 done_o); // R4
    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_ld_i && !rd_pend_q) |=> $stable(lat_o)); // R3
    AST_RD_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && wr_req_i) |=> !$past(u_mem.we)); // R8
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !any_pend_q) |=> !done_o); // R11
endmodule

// File: tb/tbl_access_tb.sv
`timescale 1ns/1ps
module tbl_access_tb;
    localparam int PTR_W = 21;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ptr_ld_i = 1'b0;
    logic [PTR_W-1:0] ptr_din_i = '0;
    logic             lat_ld_i = 1'b0;
    logic [7:0]       lat_din_i = '0;
    logic             rd_req_i = 1'b0;
    logic             wr_req_i = 1'b0;
    logic [1:0]       mode_i = 2'b00;
    logic [PTR_W-1:0] ptr_o;
    logic [7:0]       lat_o;
    logic             done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] model [512];

    always #2 clk = ~clk;

    tbl_access #(.PTR_W(PTR_W), .MEM_AW(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ptr_ld_i(ptr_ld_i), .ptr_din_i(ptr_din_i),
        .lat_ld_i(lat_ld_i), .lat_din_i(lat_din_i),
        .rd_req_i(rd_req_i), .wr_req_i(wr_req_i), .mode_i(mode_i),
        .ptr_o(ptr_o), .lat_o(lat_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PTR_W-1:0] nxt_ptr(input logic [PTR_W-1:0] p, input logic [1:0] md);
        case (md)
            2'b01:   return p + 1;
            2'b10:   return p - 1;
            2'b11:   return p + 1;
            default: return p;
        endcase
    endfunction

    function automatic logic [PTR_W-1:0] acc_of(input logic [PTR_W-1:0] p, input logic [1:0] md);
        return (md == 2'b11) ? p + 1 : p;
    endfunction

    task automatic load_ptr(input logic [PTR_W-1:0] v);
        ptr_ld_i = 1'b1; ptr_din_i = v;
        @(negedge clk);
        ptr_ld_i = 1'b0;
    endtask

    task automatic load_lat(input logic [7:0] v);
        lat_ld_i = 1'b1; lat_din_i = v;
        @(negedge clk);
        lat_ld_i = 1'b0;
    endtask

    // Issue one command; returns half a cycle after the completion edge.
    task automatic cmd(input bit rd, input bit wr, input logic [1:0] md);
        rd_req_i = rd; wr_req_i = wr; mode_i = md;
        @(negedge clk);
        rd_req_i = 1'b0; wr_req_i = 1'b0; mode_i = 2'b00;
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d, input logic [1:0] md, input string req);
        logic [PTR_W-1:0] p;
        load_lat(d);
        p = ptr_o;
        cmd(1'b0, 1'b1, md);
        model[acc_of(p, md) % 512] = d;
        check(req, done_o, 1);
        check(req, ptr_o, nxt_ptr(p, md));
    endtask

    task automatic read_byte(input logic [1:0] md, input string req);
        logic [PTR_W-1:0] p;
        p = ptr_o;
        cmd(1'b1, 1'b0, md);
        check(req, lat_o, model[acc_of(p, md) % 512]);
        check(req, done_o, 1);
        check(req, ptr_o, nxt_ptr(p, md));
        @(negedge clk);
        check(req, done_o, 0);
    endtask

    task automatic t_reset;
        check("R1 ptr", ptr_o, 0);
        check("R1 lat", lat_o, 0);
        check("R1 done", done_o, 0);
    endtask

    task automatic t_loads;
        load_ptr(21'h000123);
        check("R2 ptr load", ptr_o, 21'h000123);
        load_lat(8'hA5);
        check("R3 lat load", lat_o, 8'hA5);
        repeat (3) @(negedge clk);
        check("R3 lat hold", lat_o, 8'hA5);
    endtask

    task automatic t_lanes;
        load_ptr(21'h20);
        write_byte(8'h11, 2'b00, "R5 write low");
        load_ptr(21'h21);
        write_byte(8'h22, 2'b00, "R5 write high");
        load_ptr(21'h20);
        read_byte(2'b00, "R4 read low");
        load_ptr(21'h21);
        read_byte(2'b00, "R4 read high");
        write_byte(8'h33, 2'b00, "R5 rewrite high");
        load_ptr(21'h20);
        read_byte(2'b00, "R5 low lane kept");
        check("R5 low lane value", lat_o, 8'h11);
    endtask

    task automatic t_modes;
        load_ptr(21'h40);
        write_byte(8'h50, 2'b01, "R6 post-inc write");
        write_byte(8'h51, 2'b01, "R6 post-inc write");
        write_byte(8'h52, 2'b01, "R6 post-inc write");
        check("R6 ptr after three", ptr_o, 21'h43);
        load_ptr(21'h42);
        read_byte(2'b10, "R6 post-dec read");
        check("R6 post-dec byte", lat_o, 8'h52);
        read_byte(2'b11, "R6 pre-inc read");
        check("R6 pre-inc byte", lat_o, 8'h52);
        read_byte(2'b01, "R6 post-inc read");
        check("R6 post-inc byte", lat_o, 8'h52);
    endtask

    task automatic t_wrap;
        load_ptr(21'h1FFFFF);
        write_byte(8'h77, 2'b01, "R7 wrap up");
        check("R7 wrap to zero", ptr_o, 0);
        write_byte(8'h78, 2'b10, "R7 wrap down");
        check("R7 wrap to max", ptr_o, 21'h1FFFFF);
    endtask

    task automatic t_rd_wr;
        load_ptr(21'h20);
        load_lat(8'h99);
        cmd(1'b1, 1'b1, 2'b01);
        check("R8 read wins", lat_o, 8'h11);
        check("R8 single step", ptr_o, 21'h21);
        load_ptr(21'h20);
        read_byte(2'b00, "R8 memory untouched");
        check("R8 memory byte", lat_o, 8'h11);
    endtask

    task automatic t_ptr_conflict;
        load_ptr(21'h21);
        ptr_ld_i = 1'b1; ptr_din_i = 21'h60;
        rd_req_i = 1'b1; mode_i = 2'b01;
        @(negedge clk);
        ptr_ld_i = 1'b0; rd_req_i = 1'b0; mode_i = 2'b00;
        @(negedge clk);
        check("R9 load wins", ptr_o, 21'h60);
        check("R9 old ptr used", lat_o, model[9'h021]);
    endtask

    task automatic t_lat_conflict;
        load_ptr(21'h20);
        rd_req_i = 1'b1; mode_i = 2'b00;
        @(negedge clk);
        rd_req_i = 1'b0;
        lat_ld_i = 1'b1; lat_din_i = 8'hEE;
        @(negedge clk);
        lat_ld_i = 1'b0;
        check("R10 read wins latch", lat_o, 8'h11);
        @(negedge clk);
        check("R10 latch after", lat_o, 8'h11);
    endtask

    task automatic t_hold;
        logic [PTR_W-1:0] p;
        p = ptr_o;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R11 ptr hold", ptr_o, p);
            check("R11 no done", done_o, 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loads();
        t_lanes();
        t_modes();
        t_wrap();
        t_rd_wr();
        t_ptr_conflict();
        t_lat_conflict();
        t_hold();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule